// File: doc/BRIEF.md
# On-Screen Display Character Pixel Renderer

This block produces the overlay video for a text on-screen display, one pixel at a time. For each pixel an upstream cell timer gives the character code, a bank bit, a per-character attribute word, the source column and row inside the character cell, and the sub-pixel phase inside an enlarged pixel. The renderer works out the glyph row bits from an internal computed font. It then applies italics, underline, blink, an optional dark outline around strokes, and corner smoothing for enlarged text. It drives three colour bits and a keying signal, and the keying signal tells the downstream mixer to replace the picture.

The upstream timer owns the scale stepping: at 2x or 3x it repeats each source coordinate and advances the sub-pixel phase. The renderer uses the phase only to place smoothing pixels. A small write port sets the global outline enable and the scale mode. A frame pulse drives the blink timer. Every pixel carries its own attributes, so colours and effects can change from one character to the next.

Top module: `osd_pix_render`

## Requirements
- R1: The glyph is picked by {bank_sel, char_code}. With B = char_code XOR {8{bank_sel}}, source row r of the cell (CELL_ROWS = 10) is empty for r = 0 and for r >= CELL_ROWS-2. Every other row equals (B rotated left by r mod 8) AND 8'h7E. Source column c (0 = leftmost) is lit when bit 7-c of that row is set.
- R2: A pixel presented with pix_valid_i high at a clock edge appears on the outputs after the second following edge, with pix_valid_o high. When pix_valid_o is low, rgb_o is 0 and blank_o is 0.
- R3: The attribute word is laid out as {transparent[9], blink[8], italic[7], underline[6], bg[5:3], fg[2:0]}. A lit pixel drives fg onto rgb_o and an unlit, non-outline pixel drives bg. rgb_o bit 2 is red, bit 1 green and bit 0 blue.
- R4: When underline is set, every column of source row CELL_ROWS-1 is drawn in the foreground colour.
- R5: When italic is set, source row r is shifted right by (CELL_ROWS-1-r)/2 pixels, and bits that pass the right edge are lost. The shift applies to every row used for outline and smoothing as well.
- R6: With outline enabled (config bit 0), an unlit, non-underline pixel that has a lit glyph pixel among its eight neighbours in the same cell is drawn with colour 0 and blank_o high, even when the background is transparent.
- R7: Config bits 2:1 pick the scale: 0 = 1x, 1 = 2x, 2 = 3x, 3 = 1x. At 2x or 3x, take an unlit source pixel whose horizontal neighbour on side h and vertical neighbour on side v are both lit while the diagonal pixel between them is unlit. Its sub-pixel at the corner facing h and v (sub_col 0 or n-1, sub_row 0 or n-1) is drawn in the foreground colour.
- R8: A frame counter counts frame_tick pulses from reset. The blink off phase holds while (count / 32) is odd, modulo 64. In the off phase a character with blink set shows no glyph, underline, smoothing or outline: all of its pixels are background.
- R9: With transparent set, background pixels give blank_o = 0 and rgb_o = 0. With transparent clear, blank_o is 1 on every valid pixel.
- R10: The attributes are taken per pixel, so different attributes on consecutive pixels take effect with no gap.
- R11: Reset clears the outputs, sets the scale to 1x, disables the outline and clears the frame counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_wdata | input | 3 | Config value: bit 0 outline enable, bits 2:1 scale code |
| frame_tick | input | 1 | One-cycle pulse per video frame |
| pix_valid_i | input | 1 | Pixel inputs are valid this cycle |
| char_code | input | 8 | Character code inside the bank |
| bank_sel | input | 1 | Glyph bank select |
| attr_i | input | 10 | Per-character attribute word |
| src_col | input | 3 | Source column inside the cell |
| src_row | input | 4 | Source row inside the cell |
| sub_col | input | 2 | Horizontal phase inside an enlarged pixel |
| sub_row | input | 2 | Vertical phase inside an enlarged pixel |
| pix_valid_o | output | 1 | Output pixel valid |
| rgb_o | output | 3 | Overlay colour, red in bit 2 |
| blank_o | output | 1 | Overlay replaces the picture on this pixel |

## Verification
The assertions assume that the upstream timer keeps each valid pixel's sub-pixel phases below the current scale factor and its source row inside the cell. The bench keeps to this by walking every row, column and phase only up to the factor it has itself programmed. Before it writes the config register or sends frame pulses, it lets the pipeline drain, so no pixel in flight is caught by a change of scale, outline or blink phase.

// File: rtl/osd_pkg.sv
package osd_pkg;

  localparam int CODE_W = 8;
  localparam int CELL_W = 8;
  localparam int ATTR_W = 10;

  typedef struct packed {
    logic       transparent;
    logic       blink;
    logic       italic;
    logic       underline;
    logic [2:0] bg;
    logic [2:0] fg;
  } osd_attr_t;

  typedef enum logic [1:0] {
    SCALE_1X  = 2'd0,
    SCALE_2X  = 2'd1,
    SCALE_3X  = 2'd2,
    SCALE_RSV = 2'd3
  } scale_e;

  function automatic int scale_factor(logic [1:0] code);
    case (scale_e'(code))
      SCALE_2X: return 2;
      SCALE_3X: return 3;
      default:  return 1;
    endcase
  endfunction

endpackage

// File: rtl/osd_glyph_rows.sv
module osd_glyph_rows import osd_pkg::*; #(
  parameter int CELL_ROWS     = 10,
  parameter int ITAL_GRP_LOG2 = 1,
  localparam int RW = $clog2(CELL_ROWS)
) (
  input  logic [CODE_W-1:0] code,
  input  logic              bank,
  input  logic [RW-1:0]     row,
  input  logic              italic,
  output logic [CELL_W-1:0] row_up,
  output logic [CELL_W-1:0] row_mid,
  output logic [CELL_W-1:0] row_dn
);

  // Computed font: rotation of the bank-adjusted code, outer columns kept clear
  function automatic logic [CELL_W-1:0] row_bits(logic [CODE_W-1:0] c, logic b, int r, logic ital);
    logic [CODE_W-1:0]   base;
    logic [2*CODE_W-1:0] dbl;
    logic [CELL_W-1:0]   pat;
    int                  sh;
    if (r < 1 || r > CELL_ROWS - 3) return '0;
    base = c ^ {CODE_W{b}};
    dbl  = {base, base} << (r % CODE_W);
    pat  = dbl[2*CODE_W-1:CODE_W] & 8'h7E;
    sh   = ital ? ((CELL_ROWS - 1 - r) >> ITAL_GRP_LOG2) : 0;
    return pat >> sh;
  endfunction

  always_comb begin
    row_up  = row_bits(code, bank, int'(row) - 1, italic);
    row_mid = row_bits(code, bank, int'(row),     italic);
    row_dn  = row_bits(code, bank, int'(row) + 1, italic);
  end

endmodule

// File: rtl/osd_blink_timer.sv
module osd_blink_timer #(
  parameter int BLINK_LOG2 = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_tick,
  output logic blink_off
);

  logic [BLINK_LOG2:0] frame_cnt;

  always_ff @(posedge clk) begin
    if (rst)             frame_cnt <= '0;
    else if (frame_tick) frame_cnt <= frame_cnt + 1'b1;
  end

  assign blink_off = frame_cnt[BLINK_LOG2];

  AST_BLINK_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (frame_tick && (&frame_cnt[BLINK_LOG2-1:0])) |=> (blink_off != $past(blink_off))); // R8
  AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_tick |=> $stable(blink_off)); // R8

endmodule

// File: rtl/osd_pixel_shade.sv
module osd_pixel_shade import osd_pkg::*; #(
  parameter int CELL_ROWS = 10,
  localparam int RW = $clog2(CELL_ROWS),
  localparam int CW = $clog2(CELL_W)
) (
  input  logic [CELL_W-1:0] row_up,
  input  logic [CELL_W-1:0] row_mid,
  input  logic [CELL_W-1:0] row_dn,
  input  logic [CW-1:0]     col,
  input  logic [RW-1:0]     row,
  input  logic [1:0]        sub_col,
  input  logic [1:0]        sub_row,
  input  osd_attr_t         attr,
  input  logic [1:0]        scale,
  input  logic              outline_en,
  input  logic              blink_off,
  output logic [2:0]        rgb,
  output logic              blank
);

  function automatic logic px(logic [CELL_W-1:0] r, int c);
    if (c < 0 || c > CELL_W - 1) return 1'b0;
    return r[CELL_W-1-c];
  endfunction

  logic [CELL_W-1:0] up, mid, dn, vrow;
  logic              hide, glyph, ul_on, ring, smooth;
  int                c, n, h, sx, sy;

  always_comb begin
    hide  = attr.blink && blink_off;
    up    = hide ? '0 : row_up;
    mid   = hide ? '0 : row_mid;
    dn    = hide ? '0 : row_dn;
    ul_on = !hide && attr.underline && (int'(row) == CELL_ROWS - 1);
    c     = int'(col);
    n     = scale_factor(scale);
    glyph = px(mid, c);
    ring  = px(up, c - 1) | px(up, c) | px(up, c + 1) |
            px(mid, c - 1) | px(mid, c + 1) |
            px(dn, c - 1) | px(dn, c) | px(dn, c + 1);
    smooth = 1'b0;
    for (int hi = 0; hi < 2; hi++) begin
      for (int vi = 0; vi < 2; vi++) begin
        h    = (hi == 1) ? 1 : -1;
        sx   = (hi == 1) ? n - 1 : 0;
        sy   = (vi == 1) ? n - 1 : 0;
        vrow = (vi == 1) ? dn : up;
        if (n > 1 && !glyph && px(mid, c + h) && px(vrow, c) && !px(vrow, c + h) &&
            int'(sub_col) == sx && int'(sub_row) == sy)
          smooth = 1'b1;
      end
    end
    if (glyph || smooth || ul_on) begin
      rgb   = attr.fg;
      blank = 1'b1;
    end else if (outline_en && ring) begin
      rgb   = 3'b000;
      blank = 1'b1;
    end else if (attr.transparent) begin
      rgb   = 3'b000;
      blank = 1'b0;
    end else begin
      rgb   = attr.bg;
      blank = 1'b1;
    end
  end

endmodule

// File: rtl/osd_pix_render.sv
module osd_pix_render import osd_pkg::*; #(
  parameter int CELL_ROWS     = 10,
  parameter int BLINK_LOG2    = 5,
  parameter int ITAL_GRP_LOG2 = 1,
  localparam int RW = $clog2(CELL_ROWS),
  localparam int CW = $clog2(CELL_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_wdata,
  input  logic              frame_tick,
  input  logic              pix_valid_i,
  input  logic [CODE_W-1:0] char_code,
  input  logic              bank_sel,
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [CW-1:0]     src_col,
  input  logic [RW-1:0]     src_row,
  input  logic [1:0]        sub_col,
  input  logic [1:0]        sub_row,
  output logic              pix_valid_o,
  output logic [2:0]        rgb_o,
  output logic              blank_o
);

  osd_attr_t         in_attr;
  logic              cfg_outline;
  logic [1:0]        cfg_scale;
  logic              blink_off;
  logic [CELL_W-1:0] f_up, f_mid, f_dn;

  logic              s1_valid;
  osd_attr_t         s1_attr;
  logic [CELL_W-1:0] s1_up, s1_mid, s1_dn;
  logic [CW-1:0]     s1_col;
  logic [RW-1:0]     s1_row;
  logic [1:0]        s1_sx, s1_sy;
  logic              s1_boff;

  logic [2:0]        sh_rgb;
  logic              sh_blank;

  assign in_attr = osd_attr_t'(attr_i);

  // Global configuration register
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_outline <= 1'b0;
      cfg_scale   <= SCALE_1X;
    end else if (cfg_we) begin
      cfg_outline <= cfg_wdata[0];
      cfg_scale   <= cfg_wdata[2:1];
    end
  end

  osd_blink_timer #(.BLINK_LOG2(BLINK_LOG2)) u_blink (
    .clk        (clk),
    .rst        (rst),
    .frame_tick (frame_tick),
    .blink_off  (blink_off)
  );

  osd_glyph_rows #(.CELL_ROWS(CELL_ROWS), .ITAL_GRP_LOG2(ITAL_GRP_LOG2)) u_font (
    .code    (char_code),
    .bank    (bank_sel),
    .row     (src_row),
    .italic  (in_attr.italic),
    .row_up  (f_up),
    .row_mid (f_mid),
    .row_dn  (f_dn)
  );

  // Stage 1: font read and pixel context
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_attr  <= '0;
      s1_up    <= '0;
      s1_mid   <= '0;
      s1_dn    <= '0;
      s1_col   <= '0;
      s1_row   <= '0;
      s1_sx    <= '0;
      s1_sy    <= '0;
      s1_boff  <= 1'b0;
    end else begin
      s1_valid <= pix_valid_i;
      s1_attr  <= in_attr;
      s1_up    <= f_up;
      s1_mid   <= f_mid;
      s1_dn    <= f_dn;
      s1_col   <= src_col;
      s1_row   <= src_row;
      s1_sx    <= sub_col;
      s1_sy    <= sub_row;
      s1_boff  <= blink_off;
    end
  end

  osd_pixel_shade #(.CELL_ROWS(CELL_ROWS)) u_shade (
    .row_up     (s1_up),
    .row_mid    (s1_mid),
    .row_dn     (s1_dn),
    .col        (s1_col),
    .row        (s1_row),
    .sub_col    (s1_sx),
    .sub_row    (s1_sy),
    .attr       (s1_attr),
    .scale      (cfg_scale),
    .outline_en (cfg_outline),
    .blink_off  (s1_boff),
    .rgb        (sh_rgb),
    .blank      (sh_blank)
  );

  // Stage 2: registered video outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid_o <= 1'b0;
      rgb_o       <= '0;
      blank_o     <= 1'b0;
    end else begin
      pix_valid_o <= s1_valid;
      rgb_o       <= s1_valid ? sh_rgb : 3'b000;
      blank_o     <= s1_valid && sh_blank;
    end
  end

  AST_SUB_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    pix_valid_i |-> (int'(sub_col) < scale_factor(cfg_scale) &&
                     int'(sub_row) < scale_factor(cfg_scale) &&
                     int'(src_row) < CELL_ROWS)); // R7
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    pix_valid_i |-> ##2 pix_valid_o); // R2
  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
    !pix_valid_i |-> ##2 !pix_valid_o); // R2
  AST_OPAQUE_KEYS: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && !s1_attr.transparent) |=> blank_o); // R9

endmodule

// File: tb/osd_pix_render_tb.sv
module osd_pix_render_tb;

  localparam int ROWS = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic       frame_tick = 1'b0;
  logic       pix_valid_i = 1'b0;
  logic [7:0] char_code = '0;
  logic       bank_sel = 1'b0;
  logic [9:0] attr_i = '0;
  logic [2:0] src_col = '0;
  logic [3:0] src_row = '0;
  logic [1:0] sub_col = '0;
  logic [1:0] sub_row = '0;
  logic       pix_valid_o;
  logic [2:0] rgb_o;
  logic       blank_o;

  int checks = 0;
  int failures = 0;
  int frames = 0;
  int cur_n = 1;
  logic cur_outline = 1'b0;
  bit done = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] exp_v;
  string      exp_t;

  always #2.5 clk = ~clk;

  osd_pix_render u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .frame_tick(frame_tick), .pix_valid_i(pix_valid_i), .char_code(char_code),
    .bank_sel(bank_sel), .attr_i(attr_i), .src_col(src_col), .src_row(src_row),
    .sub_col(sub_col), .sub_row(sub_row), .pix_valid_o(pix_valid_o),
    .rgb_o(rgb_o), .blank_o(blank_o)
  );

  function automatic logic [9:0] mk_attr(logic [2:0] fg, logic [2:0] bg, bit ul, bit it, bit bl, bit tr);
    return {tr, bl, it, ul, bg, fg};
  endfunction

  // R1 and R5 model: lit state of source pixel (c, r)
  function automatic bit lit(logic [7:0] code, bit bank, int r, int c, bit ital);
    int sh, sc, pos;
    logic [7:0] b;
    if (r < 1 || r > ROWS - 3 || c < 0 || c > 7) return 0;
    sh = ital ? (ROWS - 1 - r) / 2 : 0;
    sc = c - sh;
    if (sc < 1 || sc > 6) return 0;
    b = code ^ {8{bank}};
    pos = (((7 - sc) - (r % 8)) % 8 + 8) % 8;
    return b[pos];
  endfunction

  function automatic logic [3:0] model(logic [7:0] code, bit bank, logic [9:0] a,
                                       int c, int r, int sx, int sy);
    bit ital, hide, g, ul, ring, sm;
    ital = a[7];
    hide = a[8] && (((frames / 32) % 2) == 1);
    g  = !hide && lit(code, bank, r, c, ital);
    ul = !hide && a[6] && (r == ROWS - 1);
    ring = 0;
    sm = 0;
    if (!hide) begin
      for (int dy = -1; dy <= 1; dy++)
        for (int dx = -1; dx <= 1; dx++)
          if ((dx != 0 || dy != 0) && lit(code, bank, r + dy, c + dx, ital)) ring = 1;
      if (cur_n > 1 && !g)
        for (int h = -1; h <= 1; h += 2)
          for (int v = -1; v <= 1; v += 2)
            if (lit(code, bank, r, c + h, ital) && lit(code, bank, r + v, c, ital) &&
                !lit(code, bank, r + v, c + h, ital) &&
                sx == ((h > 0) ? cur_n - 1 : 0) && sy == ((v > 0) ? cur_n - 1 : 0))
              sm = 1;
    end
    if (g || sm || ul) return {1'b1, a[2:0]};
    if (cur_outline && ring) return 4'b1000;
    if (a[9]) return 4'b0000;
    return {1'b1, a[5:3]};
  endfunction

  task automatic send(logic [7:0] code, bit bank, logic [9:0] a, int c, int r, int sx, int sy, string tag);
    pix_valid_i = 1'b1;
    char_code = code; bank_sel = bank; attr_i = a;
    src_col = 3'(c); src_row = 4'(r); sub_col = 2'(sx); sub_row = 2'(sy);
    exp_q.push_back(model(code, bank, a, c, r, sx, sy));
    tag_q.push_back(tag);
    @(negedge clk);
    pix_valid_i = 1'b0;
  endtask

  task automatic sweep(logic [7:0] code, bit bank, logic [9:0] a, string tag);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < 8; c++)
        for (int sy = 0; sy < cur_n; sy++)
          for (int sx = 0; sx < cur_n; sx++)
            send(code, bank, a, c, r, sx, sy, tag);
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  task automatic write_cfg(logic [1:0] scale, bit outline);
    drain();
    cfg_we = 1'b1; cfg_wdata = {scale, outline};
    @(negedge clk);
    cfg_we = 1'b0;
    cur_outline = outline;
    cur_n = (scale == 2'd1) ? 2 : (scale == 2'd2) ? 3 : 1;
  endtask

  task automatic ticks(int k);
    drain();
    for (int i = 0; i < k; i++) begin
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
      frames++;
    end
    @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && pix_valid_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R2: output pixel with none expected, got blank=%0b rgb=%0h expected no pixel",
                 blank_o, rgb_o);
      end else begin
        exp_v = exp_q.pop_front();
        exp_t = tag_q.pop_front();
        if ({blank_o, rgb_o} !== exp_v) begin
          failures++;
          $display("FAIL %s: got blank=%0b rgb=%0h expected blank=%0b rgb=%0h",
                   exp_t, blank_o, rgb_o, exp_v[3], exp_v[2:0]);
        end
      end
    end
  end

  task automatic check_idle(string tag);
    checks++;
    if (pix_valid_o !== 1'b0 || rgb_o !== 3'b000 || blank_o !== 1'b0) begin
      failures++;
      $display("FAIL %s: got valid=%0b blank=%0b rgb=%0h expected all zero",
               tag, pix_valid_o, blank_o, rgb_o);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R11 reset");
    rst = 1'b0;
    @(negedge clk);

    sweep(8'h3C, 1'b0, mk_attr(3'd6, 3'd1, 0, 0, 0, 0), "R1 R3 bank0");
    sweep(8'h3C, 1'b1, mk_attr(3'd2, 3'd5, 0, 0, 0, 0), "R1 bank1");
    sweep(8'hA5, 1'b0, mk_attr(3'd7, 3'd0, 1, 0, 0, 0), "R4 underline");
    sweep(8'h3C, 1'b0, mk_attr(3'd4, 3'd3, 0, 1, 0, 0), "R5 italics");

    write_cfg(2'd0, 1'b1);
    sweep(8'h18, 1'b0, mk_attr(3'd7, 3'd2, 0, 0, 0, 0), "R6 outline");
    sweep(8'h5A, 1'b0, mk_attr(3'd3, 3'd2, 1, 1, 0, 1), "R6 R9 outline transparent");
    write_cfg(2'd0, 1'b0);
    sweep(8'h66, 1'b0, mk_attr(3'd5, 3'd6, 0, 0, 0, 1), "R9 transparent");

    write_cfg(2'd1, 1'b0);
    sweep(8'h01, 1'b0, mk_attr(3'd7, 3'd1, 0, 0, 0, 0), "R7 2x smoothing");
    write_cfg(2'd2, 1'b0);
    sweep(8'h81, 1'b1, mk_attr(3'd6, 3'd0, 0, 0, 0, 0), "R7 3x smoothing");
    write_cfg(2'd1, 1'b1);
    sweep(8'h24, 1'b0, mk_attr(3'd2, 3'd4, 1, 1, 0, 1), "R7 R6 2x italic outline");
    write_cfg(2'd3, 1'b0);
    sweep(8'h01, 1'b0, mk_attr(3'd7, 3'd1, 0, 0, 0, 0), "R7 code3 as 1x");

    write_cfg(2'd0, 1'b1);
    sweep(8'h3C, 1'b0, mk_attr(3'd1, 3'd6, 1, 0, 1, 0), "R8 blink on phase");
    ticks(32);
    sweep(8'h3C, 1'b0, mk_attr(3'd1, 3'd6, 1, 0, 1, 0), "R8 blink off phase");
    sweep(8'h3C, 1'b0, mk_attr(3'd1, 3'd6, 1, 0, 1, 1), "R8 R9 blink off transparent");
    sweep(8'h3C, 1'b0, mk_attr(3'd1, 3'd6, 1, 0, 0, 0), "R8 no blink in off phase");
    ticks(32);
    sweep(8'h3C, 1'b0, mk_attr(3'd1, 3'd6, 1, 0, 1, 0), "R8 blink back on");

    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < 8; c++)
        send(8'h3C, c[0], (c % 2 == 1) ? mk_attr(3'd2, 3'd5, 1, 1, 0, 1) : mk_attr(3'd6, 3'd1, 0, 0, 0, 0),
             c, r, 0, 0, "R10 per-pixel attributes");

    send(8'h3C, 1'b0, mk_attr(3'd7, 3'd1, 0, 0, 0, 0), 3, 3, 0, 0, "R2 gap before");
    repeat (3) @(negedge clk);
    send(8'h3C, 1'b0, mk_attr(3'd7, 3'd1, 0, 0, 0, 0), 0, 0, 0, 0, "R2 gap after");
    drain();
    check_idle("R2 idle");

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R2: got %0d pixels never produced expected 0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got no completion expected finish before timeout");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule